// File: doc/BRIEF.md
# SPI Receive Queue with Overflow Policy

This block sits between the receive side of an SPI serializer and the register-read path used by a processor or DMA engine. Each completed frame from the serializer is first caught in a single-entry holding stage, the shift register's own buffer. It then moves into a circular queue whenever the queue has room. An occupancy count tells the reader how many frames are waiting, and each read of the pop port removes the oldest one.

Overflow occurs when the queue and the holding stage are both occupied and yet another frame arrives. In that case a sticky overflow flag is raised. A configuration input chooses what happens to the new frame: either it replaces the content of the holding stage, or it is thrown away. A second sticky flag, the drain flag, announces that data has been available. Software clears either flag by writing 1 to its status bit. The drain flag also clears on a DMA read-complete strobe once the queue is empty.

Top module: `spi_rx_queue`

## Requirements
- R1: A frame presented on `frame_valid` is captured in the holding stage at that clock edge. At the next edge it moves into the queue if `fill_count` is below DEPTH, and each such move raises `fill_count` by exactly one.
- R2: The queue is first-in first-out. `pop_data` always shows the oldest queued frame. A cycle with `pop_req` high and `fill_count` nonzero removes that frame and lowers `fill_count` by one.
- R3: A `pop_req` while `fill_count` is zero changes nothing: the count stays zero and no later frame is lost or reordered.
- R4: A frame that arrives while the holding stage is occupied and `fill_count` equals DEPTH sets `overflow_flag` at that edge. The flag stays set afterwards.
- R5: With `overwrite_en` high, the overflowing frame replaces the frame in the holding stage. With it low, the overflowing frame is discarded and the held frame is kept.
- R6: `drain_flag` is high after any edge that leaves at least one frame queued. It remains high after the queue empties until a clear event.
- R7: `drain_flag` clears on an edge that leaves the queue empty together with either `dma_done` high, or `sts_wr` high with `sts_wdata` bit 0 set. While frames remain queued, neither event clears it.
- R8: `overflow_flag` clears only on an edge with `sts_wr` high and `sts_wdata` bit 1 set, and only when no new overflow occurs on that same edge. Writing 0 to either status bit has no effect.
- R9: When a frame moves from the holding stage into the queue on the same edge as a pop, and the queue is neither empty nor full, both take effect and `fill_count` is unchanged.
- R10: `rst_n` low empties the queue and the holding stage and clears both flags at once, without waiting for a clock. The release takes effect two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| overwrite_en | input | 1 | 1: an overflowing frame replaces the held frame; 0: it is discarded |
| frame_valid | input | 1 | One-cycle strobe, a received frame is complete |
| frame_data | input | WIDTH | Received frame |
| pop_req | input | 1 | One read of the pop register |
| pop_data | output | WIDTH | Oldest queued frame (undefined when empty) |
| fill_count | output | clog2(DEPTH+1) | Number of queued frames |
| sts_wr | input | 1 | Write strobe to the status bits |
| sts_wdata | input | 2 | Write data: bit 0 drain flag, bit 1 overflow flag, 1 clears |
| dma_done | input | 1 | DMA read-complete strobe |
| drain_flag | output | 1 | Sticky data-available flag |
| overflow_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions assume the following about the inputs:
- Each frame appears as a single-cycle `frame_valid` pulse.
- `sts_wdata` is only meaningful while `sts_wr` is high.
- Inputs settle away from the rising edge.

The stimulus drives every input on the falling edge and drops each strobe after one cycle. It reads `pop_data` only while the queue holds data, since the value is undefined when the queue is empty. Coverage comes from fill-and-drain sweeps at every occupancy from 1 to DEPTH, from overflow under both policies, and from a pop that coincides with a transfer out of the holding stage.

// File: rtl/spi_rxq_pkg.sv
package spi_rxq_pkg;
  localparam int unsigned STS_W         = 2;
  localparam int unsigned STS_DRAIN_BIT = 0;
  localparam int unsigned STS_OVF_BIT   = 1;
endpackage

// File: rtl/spi_rxq_rst_sync.sv
module spi_rxq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/spi_rxq_hold.sv
module spi_rxq_hold #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_valid_i,
  input  logic [WIDTH-1:0] frame_data_i,
  input  logic             overwrite_en_i,
  input  logic             room_i,
  output logic             push_o,
  output logic [WIDTH-1:0] push_data_o,
  output logic             ovf_evt_o
);
  logic             full_q, full_d;
  logic [WIDTH-1:0] data_q, data_d;
  logic             load;

  always_comb begin
    push_o    = full_q & room_i;
    ovf_evt_o = frame_valid_i & full_q & ~room_i;
    load      = frame_valid_i & (~ovf_evt_o | overwrite_en_i);
    full_d    = frame_valid_i | (full_q & ~push_o);
    data_d    = load ? frame_data_i : data_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign push_data_o = data_q;

  // R4: an overflow can only come from an occupied stage, which stays occupied
  a_r4_ovf_keeps_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_o |=> full_q);
  // R5: discard policy leaves the held frame untouched
  a_r5_discard_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_evt_o && !overwrite_en_i) |=> $stable(data_q));
  // R5: overwrite policy takes the new frame
  a_r5_overwrite_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_evt_o && overwrite_en_i) |=> (data_q == $past(frame_data_i)));
endmodule

// File: rtl/spi_rxq_store.sv
module spi_rxq_store #(
  parameter  int unsigned DEPTH = 4,
  parameter  int unsigned WIDTH = 16,
  localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CW-1:0]    cnt_q_o,
  output logic [CW-1:0]    cnt_d_o
);
  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [PW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = push_i ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop_i  ? bump(rd_ptr_q) : rd_ptr_q;
    unique case ({push_i, pop_i})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) slot_q[wr_ptr_q] <= push_data_i;
  end

  assign head_o  = slot_q[rd_ptr_q];
  assign cnt_q_o = cnt_q;
  assign cnt_d_o = cnt_d;

  // R2: occupancy never exceeds the depth
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R1: a lone transfer adds one entry
  a_r1_push_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> (cnt_q == $past(cnt_q) + CW'(1)));
  // R2: a lone pop removes one entry
  a_r2_pop_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  // R9: transfer and pop together keep the count
  a_r9_push_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/spi_rxq_flags.sv
module spi_rxq_flags
  import spi_rxq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nonempty_next_i,
  input  logic             ovf_evt_i,
  input  logic             dma_done_i,
  input  logic             sts_wr_i,
  input  logic [STS_W-1:0] sts_wdata_i,
  output logic             drain_o,
  output logic             ovf_o
);
  logic drain_q, drain_d;
  logic ovf_q, ovf_d;
  logic drain_clr, ovf_clr;

  always_comb begin
    drain_clr = dma_done_i | (sts_wr_i & sts_wdata_i[STS_DRAIN_BIT]);
    ovf_clr   = sts_wr_i & sts_wdata_i[STS_OVF_BIT];
    drain_d   = nonempty_next_i | (drain_q & ~drain_clr);
    ovf_d     = ovf_evt_i | (ovf_q & ~ovf_clr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drain_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      drain_q <= drain_d;
      ovf_q   <= ovf_d;
    end
  end

  assign drain_o = drain_q;
  assign ovf_o   = ovf_q;

  // R6: data left in the queue forces the drain flag
  a_r6_drain_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nonempty_next_i |=> drain_q);
  // R7: without a clear event the drain flag holds
  a_r7_drain_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_q && !dma_done_i && !(sts_wr_i && sts_wdata_i[STS_DRAIN_BIT])) |=> drain_q);
  // R4: an overflow event raises the flag
  a_r4_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> ovf_q);
  // R8: overflow flag holds unless bit 1 is written with 1
  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(sts_wr_i && sts_wdata_i[STS_OVF_BIT])) |=> ovf_q);
endmodule

// File: rtl/spi_rx_queue.sv
module spi_rx_queue
  import spi_rxq_pkg::*;
#(
  parameter  int unsigned DEPTH = 4,
  parameter  int unsigned WIDTH = 16,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             overwrite_en,
  input  logic             frame_valid,
  input  logic [WIDTH-1:0] frame_data,
  input  logic             pop_req,
  output logic [WIDTH-1:0] pop_data,
  output logic [CW-1:0]    fill_count,
  input  logic             sts_wr,
  input  logic [STS_W-1:0] sts_wdata,
  input  logic             dma_done,
  output logic             drain_flag,
  output logic             overflow_flag
);
  logic             rst_sync_n;
  logic             push, pop_ok, room, ovf_evt;
  logic [WIDTH-1:0] push_data;
  logic [CW-1:0]    cnt_q, cnt_d;

  spi_rxq_rst_sync u_rst (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  assign room   = (cnt_q < CW'(DEPTH));
  assign pop_ok = pop_req & (cnt_q != '0);

  spi_rxq_hold #(.WIDTH(WIDTH)) u_hold (
    .clk_i          (clk),
    .rst_ni         (rst_sync_n),
    .frame_valid_i  (frame_valid),
    .frame_data_i   (frame_data),
    .overwrite_en_i (overwrite_en),
    .room_i         (room),
    .push_o         (push),
    .push_data_o    (push_data),
    .ovf_evt_o      (ovf_evt)
  );

  spi_rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk_i       (clk),
    .rst_ni      (rst_sync_n),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop_ok),
    .head_o      (pop_data),
    .cnt_q_o     (cnt_q),
    .cnt_d_o     (cnt_d)
  );

  spi_rxq_flags u_flags (
    .clk_i           (clk),
    .rst_ni          (rst_sync_n),
    .nonempty_next_i (cnt_d != '0),
    .ovf_evt_i       (ovf_evt),
    .dma_done_i      (dma_done),
    .sts_wr_i        (sts_wr),
    .sts_wdata_i     (sts_wdata),
    .drain_o         (drain_flag),
    .ovf_o           (overflow_flag)
  );

  assign fill_count = cnt_q;

  // R3: a pop on an empty queue with no transfer leaves it empty
  a_r3_empty_pop: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pop_req && fill_count == '0 && !push) |=> (fill_count == '0));
  // R10: while in reset the outputs show an empty, clean block
  a_r10_reset_state: assert property (@(posedge clk)
    !rst_sync_n |-> (fill_count == '0 && !drain_flag && !overflow_flag));
endmodule

// File: tb/spi_rx_queue_bench.sv
module spi_rx_queue_bench;
  localparam int CLK_P = 10;
  localparam int DEPTH = 4;
  localparam int WIDTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             overwrite_en, frame_valid, pop_req, sts_wr, dma_done;
  logic [WIDTH-1:0] frame_data, pop_data;
  logic [CW-1:0]    fill_count;
  logic [1:0]       sts_wdata;
  logic             drain_flag, overflow_flag;

  int checks = 0;
  int errors = 0;

  always #(CLK_P / 2) clk = ~clk;

  spi_rx_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_spi_rx_queue (
    .clk(clk), .rst_n(rst_n), .overwrite_en(overwrite_en),
    .frame_valid(frame_valid), .frame_data(frame_data),
    .pop_req(pop_req), .pop_data(pop_data), .fill_count(fill_count),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .dma_done(dma_done),
    .drain_flag(drain_flag), .overflow_flag(overflow_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one rising edge with the given strobes, inputs changed on falling edges
  task automatic step(input logic fv, input logic [WIDTH-1:0] fd, input logic pp,
                      input logic sw, input logic [1:0] swd, input logic dd);
    frame_valid = fv; frame_data = fd; pop_req = pp;
    sts_wr = sw; sts_wdata = swd; dma_done = dd;
    @(negedge clk);
    frame_valid = 1'b0; pop_req = 1'b0; sts_wr = 1'b0; sts_wdata = 2'b00; dma_done = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, 1'b0, 2'b00, 1'b0);
  endtask

  task automatic send(input logic [WIDTH-1:0] d);
    step(1'b1, d, 1'b0, 1'b0, 2'b00, 1'b0);
  endtask

  task automatic pop_expect(input string req, input logic [WIDTH-1:0] d);
    check(req, int'(pop_data), int'(d));
    step(1'b0, '0, 1'b1, 1'b0, 2'b00, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    overwrite_en = 1'b0; frame_valid = 1'b0; frame_data = '0; pop_req = 1'b0;
    sts_wr = 1'b0; sts_wdata = 2'b00; dma_done = 1'b0;
    do_reset();

    // R10 reset state
    check("R10 count", int'(fill_count), 0);
    check("R10 drain", int'(drain_flag), 0);
    check("R10 ovf", int'(overflow_flag), 0);

    // R1 / R2 sweep over every occupancy
    for (int n = 1; n <= DEPTH; n++) begin
      for (int k = 0; k < n; k++) send(WIDTH'(n * 16 + k));
      idle();
      check("R1 fill count", int'(fill_count), n);
      check("R6 drain set", int'(drain_flag), 1);
      for (int k = 0; k < n; k++) begin
        pop_expect("R2 order", WIDTH'(n * 16 + k));
        check("R2 count after pop", int'(fill_count), n - k - 1);
      end
      step(1'b0, '0, 1'b0, 1'b0, 2'b00, 1'b1);
      check("R7 dma clear when empty", int'(drain_flag), 0);
    end

    // R1 capture timing: one edge into holding stage, next into queue
    send(16'h00C0);
    check("R1 held not yet queued", int'(fill_count), 0);
    idle();
    check("R1 queued after next edge", int'(fill_count), 1);
    pop_expect("R2 single", 16'h00C0);
    step(1'b0, '0, 1'b0, 1'b1, 2'b01, 1'b0);

    // R4 / R5 discard policy
    overwrite_en = 1'b0;
    for (int k = 1; k <= 4; k++) send(WIDTH'(16'hA0 + k));
    idle();
    check("R1 full", int'(fill_count), DEPTH);
    send(16'h00A5);
    check("R4 no ovf with free holding stage", int'(overflow_flag), 0);
    send(16'h00A6);
    check("R4 ovf set", int'(overflow_flag), 1);
    check("R4 count at full", int'(fill_count), DEPTH);
    pop_expect("R2 A1", 16'h00A1);
    idle();
    check("R1 held frame refills", int'(fill_count), DEPTH);
    pop_expect("R2 A2", 16'h00A2);
    pop_expect("R2 A3", 16'h00A3);
    pop_expect("R2 A4", 16'h00A4);
    pop_expect("R5 discard keeps held frame", 16'h00A5);
    check("R2 empty", int'(fill_count), 0);
    check("R6 drain sticky after empty", int'(drain_flag), 1);

    // R3 pop on empty
    step(1'b0, '0, 1'b1, 1'b0, 2'b00, 1'b0);
    check("R3 empty pop count", int'(fill_count), 0);
    send(16'h00E1);
    idle();
    pop_expect("R3 no loss after empty pop", 16'h00E1);

    // R8 / R7 status writes
    step(1'b0, '0, 1'b0, 1'b1, 2'b00, 1'b0);
    check("R8 write zero keeps ovf", int'(overflow_flag), 1);
    check("R7 write zero keeps drain", int'(drain_flag), 1);
    step(1'b0, '0, 1'b0, 1'b1, 2'b10, 1'b0);
    check("R8 write one clears ovf", int'(overflow_flag), 0);
    check("R7 ovf write leaves drain", int'(drain_flag), 1);
    step(1'b0, '0, 1'b0, 1'b1, 2'b01, 1'b0);
    check("R7 write one clears drain when empty", int'(drain_flag), 0);

    // R5 overwrite policy, R7 no clear while nonempty
    overwrite_en = 1'b1;
    for (int k = 1; k <= 4; k++) send(WIDTH'(16'hB0 + k));
    idle();
    send(16'h00B5);
    send(16'h00B6);
    check("R4 ovf in overwrite mode", int'(overflow_flag), 1);
    // R8: overflow and clear on same edge, set wins
    step(1'b1, 16'h00B7, 1'b0, 1'b1, 2'b10, 1'b0);
    check("R8 new overflow beats clear", int'(overflow_flag), 1);
    pop_expect("R2 B1", 16'h00B1);
    idle();
    step(1'b0, '0, 1'b0, 1'b1, 2'b01, 1'b0);
    check("R7 write one ignored when nonempty", int'(drain_flag), 1);
    step(1'b0, '0, 1'b0, 1'b0, 2'b00, 1'b1);
    check("R7 dma ignored when nonempty", int'(drain_flag), 1);
    pop_expect("R2 B2", 16'h00B2);
    pop_expect("R2 B3", 16'h00B3);
    pop_expect("R2 B4", 16'h00B4);
    pop_expect("R5 overwrite keeps newest", 16'h00B7);
    check("R2 empty again", int'(fill_count), 0);
    overwrite_en = 1'b0;
    step(1'b0, '0, 1'b0, 1'b1, 2'b11, 1'b0);
    check("R8 cleared", int'(overflow_flag), 0);

    // R9 transfer and pop on the same edge
    send(16'h00D1);
    send(16'h00D2);
    idle();
    check("R9 setup", int'(fill_count), 2);
    send(16'h00D3);
    check("R9 held", int'(fill_count), 2);
    pop_expect("R9 pop D1", 16'h00D1);
    check("R9 count unchanged", int'(fill_count), 2);
    pop_expect("R9 pop D2", 16'h00D2);
    pop_expect("R9 pop D3", 16'h00D3);

    // R10 asynchronous assertion mid-operation
    send(16'h00F1);
    send(16'h00F2);
    idle();
    #(CLK_P / 4);
    rst_n = 1'b0;
    #1;
    check("R10 async count", int'(fill_count), 0);
    check("R10 async drain", int'(drain_flag), 0);
    @(negedge clk);
    rst_n = 1'b1;
    send(16'h0011);
    idle();
    check("R10 held in reset for two edges", int'(fill_count), 0);
    repeat (2) idle();
    send(16'h0022);
    idle();
    check("R10 operating after release", int'(fill_count), 1);
    pop_expect("R10 first frame after reset", 16'h0022);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule